// File: doc/BRIEF.md
# Serial port status flag unit

This block keeps the sticky event flags of a serial port and produces its single interrupt request. It watches a stream of received-byte strobes to track how far a block has progressed. It times idle gaps in the receive line in units of bit periods. It resynchronises and watches the active-low clear-to-send pin. It latches break reports coming from an external break detector. The serial shifter, the baud generator and the break detector themselves sit outside this block and appear only as input strobes.

Software reads four sticky flags: end-of-block, receive timeout, clear-to-send change and break. It clears any of them by writing a one to the matching bit of a separate clear command. Each flag has its own interrupt enable, and the enabled flags are combined into one registered interrupt line. The block also reports the inverted clear-to-send level and a transmit-empty indication.

Top module: `serial_status_flags`

## Requirements
- R1: After reset, all four flags, the interrupt and the transmit-empty output read 0. With the clear-to-send pin held high, the clear-to-send level also reads 0.
- R2: Flag bit 0 (end-of-block) sets on the received byte that brings the number of bytes since block start to blk_len + 4 or more. A byte sampled together with blk_start counts as the first byte. After a clear, every further byte of the same block sets the flag again.
- R3: Flag bit 1 (receive timeout) sets on the rto_limit-th bit tick after the last received byte when no other byte has arrived. A byte restarts the count. The flag sets only once per idle gap, and an rto_limit of 0 turns the timer off.
- R4: cts_level equals the inverse of cts_n_pin as it was two clock edges earlier, so a low pin reads as 1.
- R5: Flag bit 2 (clear-to-send change) sets on every transition of cts_n_pin, falling or rising. It sets on the third clock edge after the pin moves.
- R6: Flag bit 3 (break) sets on the clock edge that samples brk_det_stb high.
- R7: A 1 in bit i of clr_cmd clears flag i on that edge. A 0 bit leaves its flag unchanged. The bit positions are 0 end-of-block, 1 timeout, 2 clear-to-send change, 3 break.
- R8: When a set event and a clear of the same flag arrive on the same edge, the flag ends up set.
- R9: irq is a register that goes high one edge after any flag whose irq_en bit (same positions as R7) is 1. A set flag whose enable is 0 does not raise irq.
- R10: txe follows thr_empty with one edge of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_stb | input | 1 | One-cycle strobe per received byte |
| blk_start | input | 1 | Restarts the block byte count |
| blk_len | input | LEN_W | Programmed block length, without the 4-byte prologue |
| rto_limit | input | RTO_W | Idle timeout in bit periods, 0 disables |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| cts_n_pin | input | 1 | Raw asynchronous clear-to-send pin, active low |
| brk_det_stb | input | 1 | Break reported by the break detector |
| thr_empty | input | 1 | Holding data has moved to the shift register |
| clr_cmd | input | 4 | Write-one-to-clear command, one bit per flag |
| irq_en | input | 4 | Per-flag interrupt enable |
| flags | output | 4 | Sticky flags: end-of-block, timeout, clear-to-send change, break |
| cts_level | output | 1 | Inverted synchronised clear-to-send pin |
| txe | output | 1 | Transmit-empty indication |
| irq | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach is a hardware set and a software clear of the same flag landing on the same edge, because the two come from unrelated sources. The bench clears the end-of-block flag once the block count is already past its threshold. It then drives a received byte and the clear bit in the same cycle, so the flag must survive. The once-per-gap timeout is reached by letting ticks keep running after the flag fires, then restarting the gap with bytes placed mid-count.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

  localparam int NFLAG          = 4;
  localparam int PROLOGUE_BYTES = 4;

  localparam int FLG_EOB = 0;
  localparam int FLG_RTO = 1;
  localparam int FLG_CTS = 2;
  localparam int FLG_BRK = 3;

  // byte count at which the end-of-block condition holds
  function automatic logic [31:0] eob_threshold(input logic [31:0] len);
    return len + 32'(PROLOGUE_BYTES);
  endfunction

  // true when the tick being taken completes the idle window
  function automatic logic idle_expired(input logic [31:0] cnt, input logic [31:0] limit);
    return (limit != 32'd0) && ((cnt + 32'd1) >= limit);
  endfunction

  // sticky flag update, set has priority over clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ssf_block_counter.sv
module ssf_block_counter
  import ssf_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_byte_stb,
  input  logic             blk_start,
  input  logic [LEN_W-1:0] blk_len,
  output logic             eob_evt
);

  localparam int CNT_W = LEN_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_inc;
  logic             at_or_past;

  always_comb begin
    cnt_base = blk_start ? '0 : cnt_q;
    cnt_inc  = (cnt_base == CNT_MAX) ? cnt_base : cnt_base + 1'b1;
  end

  assign at_or_past = 32'(cnt_inc) >= eob_threshold(32'(blk_len));
  assign eob_evt    = rx_byte_stb & at_or_past;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (rx_byte_stb) begin
      cnt_q <= cnt_inc;
    end else if (blk_start) begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/ssf_idle_timer.sv
module ssf_idle_timer
  import ssf_pkg::*;
#(
  parameter int RTO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_byte_stb,
  input  logic             bit_tick,
  input  logic [RTO_W-1:0] rto_limit,
  output logic             rto_evt
);

  logic [RTO_W-1:0] cnt_q;
  logic             armed_q;
  logic             tick_live;
  logic             expire;

  assign tick_live = armed_q & bit_tick & ~rx_byte_stb;
  assign expire    = idle_expired(32'(cnt_q), 32'(rto_limit));
  assign rto_evt   = tick_live & expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rx_byte_stb) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (tick_live) begin
      if (expire) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssf_cts_monitor.sv
module ssf_cts_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_pin,
  output logic cts_level,
  output logic cts_chg_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[s] <= 1'b1;
        end else if (s == 0) begin
          sync_q[s] <= cts_n_pin;
        end else begin
          sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= synced;
  end

  assign cts_level   = ~synced;
  assign cts_chg_evt = synced ^ prev_q;

endmodule

// File: rtl/ssf_flag_bank.sv
module ssf_flag_bank
  import ssf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic [NFLAG-1:0] en_vec,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);

  logic [NFLAG-1:0] gated;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= sticky_next(flags[i], set_vec[i], clr_vec[i]);
      end
      assign gated[i] = flags[i] & en_vec[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |gated;
  end

endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
  import ssf_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int RTO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_byte_stb,
  input  logic             blk_start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [RTO_W-1:0] rto_limit,
  input  logic             bit_tick,
  input  logic             cts_n_pin,
  input  logic             brk_det_stb,
  input  logic             thr_empty,
  input  logic [3:0]       clr_cmd,
  input  logic [3:0]       irq_en,
  output logic [3:0]       flags,
  output logic             cts_level,
  output logic             txe,
  output logic             irq
);

  // named internal events, visible to the bound checker
  logic             eob_evt;
  logic             rto_evt;
  logic             cts_chg_evt;
  logic [NFLAG-1:0] set_vec;

  ssf_block_counter #(.LEN_W(LEN_W)) u_blk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_byte_stb (rx_byte_stb),
    .blk_start   (blk_start),
    .blk_len     (blk_len),
    .eob_evt     (eob_evt)
  );

  ssf_idle_timer #(.RTO_W(RTO_W)) u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_byte_stb (rx_byte_stb),
    .bit_tick    (bit_tick),
    .rto_limit   (rto_limit),
    .rto_evt     (rto_evt)
  );

  ssf_cts_monitor #(.SYNC_STAGES(2)) u_cts (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n_pin   (cts_n_pin),
    .cts_level   (cts_level),
    .cts_chg_evt (cts_chg_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_EOB] = eob_evt;
    set_vec[FLG_RTO] = rto_evt;
    set_vec[FLG_CTS] = cts_chg_evt;
    set_vec[FLG_BRK] = brk_det_stb;
  end

  ssf_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_cmd),
    .en_vec  (irq_en),
    .flags   (flags),
    .irq     (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txe <= 1'b0;
    else        txe <= thr_empty;
  end

endmodule

// File: rtl/ssf_checker.sv
module ssf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] set_vec,
  input logic [3:0] clr_cmd,
  input logic [3:0] flags,
  input logic       irq,
  input logic       cts_n_pin,
  input logic       cts_level,
  input logic       thr_empty,
  input logic       txe,
  input logic       rto_evt
);

  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  generate
    for (genvar i = 0; i < 4; i++) begin : g_flag_chk
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> flags[i]);
      assert_fall_by_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && $fell(flags[i])) |-> $past(clr_cmd[i]));
    end
  endgenerate

  assert_cts_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (cts_level == !$past(cts_n_pin, 2)));

  assert_single_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rto_evt |=> !rto_evt);

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && irq) |-> $past(|flags));

  assert_txe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) |-> (txe == $past(thr_empty)));

endmodule

bind serial_status_flags ssf_checker u_ssf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_vec   (set_vec),
  .clr_cmd   (clr_cmd),
  .flags     (flags),
  .irq       (irq),
  .cts_n_pin (cts_n_pin),
  .cts_level (cts_level),
  .thr_empty (thr_empty),
  .txe       (txe),
  .rto_evt   (rto_evt)
);

// File: tb/serial_status_flags_bench.sv
module serial_status_flags_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int RTO_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_byte_stb = 1'b0;
  logic             blk_start = 1'b0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [RTO_W-1:0] rto_limit = '0;
  logic             bit_tick = 1'b0;
  logic             cts_n_pin = 1'b1;
  logic             brk_det_stb = 1'b0;
  logic             thr_empty = 1'b0;
  logic [3:0]       clr_cmd = '0;
  logic [3:0]       irq_en = '0;
  logic [3:0]       flags;
  logic             cts_level;
  logic             txe;
  logic             irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_status_flags #(.LEN_W(LEN_W), .RTO_W(RTO_W)) u_serial_status_flags (
    .clk(clk), .rst_n(rst_n), .rx_byte_stb(rx_byte_stb), .blk_start(blk_start),
    .blk_len(blk_len), .rto_limit(rto_limit), .bit_tick(bit_tick),
    .cts_n_pin(cts_n_pin), .brk_det_stb(brk_det_stb), .thr_empty(thr_empty),
    .clr_cmd(clr_cmd), .irq_en(irq_en), .flags(flags), .cts_level(cts_level),
    .txe(txe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic byte_in(input bit start);
    blk_start = start; rx_byte_stb = 1'b1;
    @(negedge clk);
    blk_start = 1'b0; rx_byte_stb = 1'b0;
  endtask

  task automatic tick_once;
    bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
  endtask

  task automatic clear(input logic [3:0] m);
    clr_cmd = m; @(negedge clk); clr_cmd = '0;
  endtask

  task automatic t_reset;
    chk("R1 flags", 32'(flags), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 txe", 32'(txe), 0);
    chk("R1 cts_level", 32'(cts_level), 0);
  endtask

  task automatic t_eob;
    blk_len = 8'd3;               // threshold 7 bytes
    byte_in(1'b1);                // byte 1 with block start
    for (int k = 0; k < 5; k++) byte_in(1'b0);   // bytes 2..6
    chk("R2 below threshold", 32'(flags[0]), 0);
    byte_in(1'b0);                // byte 7
    chk("R2 at threshold", 32'(flags[0]), 1);
    clear(4'b0001);
    chk("R7 clear eob", 32'(flags[0]), 0);
    byte_in(1'b0);                // byte 8 exceeds
    chk("R2 past threshold", 32'(flags[0]), 1);
    clear(4'b0001);
    clr_cmd = 4'b0001; rx_byte_stb = 1'b1;
    @(negedge clk);
    clr_cmd = '0; rx_byte_stb = 1'b0;
    chk("R8 set beats clear", 32'(flags[0]), 1);
    byte_in(1'b1);                // new block, byte 1
    clear(4'b0001);
    byte_in(1'b0);
    chk("R2 restart count", 32'(flags[0]), 0);
    clear(4'hF);
  endtask

  task automatic t_rto;
    rto_limit = 16'd4;
    byte_in(1'b0);
    for (int k = 0; k < 3; k++) tick_once();
    chk("R3 before limit", 32'(flags[1]), 0);
    tick_once();
    chk("R3 at limit", 32'(flags[1]), 1);
    clear(4'b0010);
    for (int k = 0; k < 6; k++) tick_once();
    chk("R3 once per gap", 32'(flags[1]), 0);
    byte_in(1'b0);
    tick_once(); tick_once();
    byte_in(1'b0);
    for (int k = 0; k < 3; k++) tick_once();
    chk("R3 reload on byte", 32'(flags[1]), 0);
    tick_once();
    chk("R3 after reload", 32'(flags[1]), 1);
    clear(4'hF);
    rto_limit = 16'd0;
    byte_in(1'b0);
    for (int k = 0; k < 8; k++) tick_once();
    chk("R3 zero disables", 32'(flags[1]), 0);
    clear(4'hF);
  endtask

  task automatic t_cts;
    chk("R4 pin high", 32'(cts_level), 0);
    cts_n_pin = 1'b0;
    cycles(2);
    chk("R4 pin low reads 1", 32'(cts_level), 1);
    chk("R5 not yet", 32'(flags[2]), 0);
    cycles(1);
    chk("R5 falling edge", 32'(flags[2]), 1);
    clear(4'b0100);
    chk("R7 clear cts", 32'(flags[2]), 0);
    cts_n_pin = 1'b1;
    cycles(3);
    chk("R5 rising edge", 32'(flags[2]), 1);
    chk("R4 back high", 32'(cts_level), 0);
    clear(4'hF);
  endtask

  task automatic t_brk_and_clear;
    brk_det_stb = 1'b1; @(negedge clk); brk_det_stb = 1'b0;
    chk("R6 break set", 32'(flags[3]), 1);
    clear(4'b0001);
    chk("R7 zero bit keeps break", 32'(flags[3]), 1);
    clear(4'b0000);
    chk("R7 empty write", 32'(flags[3]), 1);
    clear(4'b1000);
    chk("R7 clear break", 32'(flags[3]), 0);
  endtask

  task automatic t_irq;
    brk_det_stb = 1'b1; @(negedge clk); brk_det_stb = 1'b0;
    cycles(1);
    chk("R9 disabled flag quiet", 32'(irq), 0);
    irq_en = 4'b0001;
    cycles(2);
    chk("R9 other enable quiet", 32'(irq), 0);
    irq_en = 4'b1000;
    cycles(1);
    chk("R9 enabled raises", 32'(irq), 1);
    clear(4'b1000);
    chk("R9 lags clear", 32'(irq), 1);
    cycles(1);
    chk("R9 drops", 32'(irq), 0);
    irq_en = '0;
  endtask

  task automatic t_txe;
    thr_empty = 1'b1; @(negedge clk);
    chk("R10 rise", 32'(txe), 1);
    thr_empty = 1'b0; @(negedge clk);
    chk("R10 fall", 32'(txe), 0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    t_reset();
    t_eob();
    t_rto();
    t_cts();
    t_brk_and_clear();
    t_irq();
    t_txe();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule